// File: doc/BRIEF.md
# Dual-Count PWM Generator with Shadowed Counts

This block produces one pulse-width-modulated output whose waveform is described by two independent cycle counts: how many clocks the output spends high, and how many it spends low afterwards. Software programs both counts through a plain single-cycle register bus. Each access is one address, a write strobe and write data, with read data returned combinationally. The counts first land in shadow registers. They reach the running generator only when software writes the control word with its update bit set. This lets a new high/low pair take effect as one atomic change.

If the generator is idle when the update arrives, the counts are taken at once. If a period is in progress, the new counts wait for that period to finish, so no period is ever built from a mix of old and new values. The bus has no back-pressure: every write is accepted in the cycle its strobe is high, and reads need no handshake. Three further control bits (mode, trigger, invert) are stored and read back but do not affect the output.

Top module: `dcp_pwm_top`

## Requirements
- R1: An asynchronous active-low reset clears the control word, both shadow counts and both active counts to zero, and the output is low.
- R2: Byte offset 0x00 is the control word, 0x18 the low-cycle count and 0x1C the high-cycle count. A read of one of these offsets returns the stored value. Any other offset reads zero, and a write to any other offset changes nothing.
- R3: Writing a count register changes only the shadow copy. A control write whose bit 5 (update) is clear leaves the running waveform unchanged.
- R4: The output can be high only while control bit 0 (enable) and bit 14 (drive) are both set. With either bit clear, the output is low and the next start begins a fresh period.
- R5: While running, each period drives the output high for the active high count of clocks and then low for the active low count, and this repeats.
- R6: With an active high count of zero, the output stays low. This includes the case where both counts are zero.
- R7: With a nonzero high count and a zero low count, the output stays high while running.
- R8: An update issued while the generator is idle copies the shadow counts in the same clock edge. The first sample after that edge is cycle 0 of a new period.
- R9: An update issued while a period is running is held back until the end of that period. The new counts then start at cycle 0 of the following period.
- R10: Control bits 2, 9 and 10 are stored and read back but do not change the output waveform.
- R11: Each count is 32 bits wide. The period length, which can need 33 bits, is formed without overflow, so all-ones counts give a long high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Generator and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe; the write takes effect at the next rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
Every high/low pair with both counts from 0 to 4 is programmed from idle and followed for more than two periods. The expected level at each sample is the sample index modulo the period length, compared against the high count. This sweep separates the ordinary waveform from the zero-high and zero-low cases. Patterns that also carry the mode, trigger and invert bits must give exactly the same waveform. A separate running sequence rewrites the shadows and issues control writes with and without the update bit at known phases, which separates a held-back commit from an immediate one or from a leak of the shadows. Gating with only one of the two run bits, all-ones counts, and an unmapped offset complete the patterns.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
  // Byte offsets decoded by software
  localparam int unsigned OFS_CTRL = 'h00;
  localparam int unsigned OFS_LOW  = 'h18;
  localparam int unsigned OFS_HIGH = 'h1C;

  // Control word bit positions
  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_MODE = 2;
  localparam int unsigned BIT_UPD  = 5;
  localparam int unsigned BIT_TRIG = 9;
  localparam int unsigned BIT_INV  = 10;
  localparam int unsigned BIT_DRV  = 14;

  typedef struct packed {
    logic idle;      // not running, or period length is zero
    logic boundary;  // last cycle of the current period
  } gen_stat_t;
endpackage

// File: rtl/dcp_regs.sv
module dcp_regs
  import dcp_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  shd_high,
  output logic [CNT_W-1:0]  shd_low,
  output logic              run_q,
  output logic              upd_req,
  output logic              upd_run
);
  logic [DATA_W-1:0] ctrl_q;
  logic hit_ctrl, hit_low, hit_high;

  always_comb begin
    hit_ctrl = (addr == ADDR_W'(OFS_CTRL));
    hit_low  = (addr == ADDR_W'(OFS_LOW));
    hit_high = (addr == ADDR_W'(OFS_HIGH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      shd_high <= '0;
      shd_low  <= '0;
    end else if (we) begin
      if (hit_ctrl) ctrl_q   <= wdata;
      if (hit_low)  shd_low  <= wdata[CNT_W-1:0];
      if (hit_high) shd_high <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_ctrl)      rdata = ctrl_q;
    else if (hit_low)  rdata[CNT_W-1:0] = shd_low;
    else if (hit_high) rdata[CNT_W-1:0] = shd_high;
  end

  always_comb begin
    run_q   = ctrl_q[BIT_EN] & ctrl_q[BIT_DRV];
    upd_req = we & hit_ctrl & wdata[BIT_UPD];
    upd_run = wdata[BIT_EN] & wdata[BIT_DRV];
  end

  AST_SHADOW_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && hit_high) |=> $stable(shd_high)); // R2
  AST_SHADOW_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && hit_low) |=> $stable(shd_low)); // R2
endmodule

// File: rtl/dcp_commit.sv
module dcp_commit
  import dcp_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_req,
  input  logic             upd_run,
  input  logic [CNT_W-1:0] shd_high,
  input  logic [CNT_W-1:0] shd_low,
  input  gen_stat_t        stat,
  output logic [CNT_W-1:0] act_high,
  output logic [CNT_W-1:0] act_low,
  output logic             load
);
  logic pending;
  logic want;

  always_comb begin
    want = pending | upd_req;
    // copy now if nothing runs, the period ends, or the update stops the generator
    load = want & (stat.idle | stat.boundary | (upd_req & ~upd_run));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      act_high <= '0;
      act_low  <= '0;
    end else begin
      pending <= want & ~load;
      if (load) begin
        act_high <= shd_high;
        act_low  <= shd_low;
      end
    end
  end

  AST_DEFER_WHILE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_req && upd_run && !stat.idle && !stat.boundary) |=> ($stable(act_high) && $stable(act_low))); // R9
  AST_NO_SPONTANEOUS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_req && !pending) |=> ($stable(act_high) && $stable(act_low))); // R3
endmodule

// File: rtl/dcp_gen.sv
module dcp_gen
  import dcp_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] act_high,
  input  logic [CNT_W-1:0] act_low,
  output logic             pwm_out,
  output gen_stat_t        stat
);
  localparam int unsigned SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] total;
  logic [SUM_W-1:0] pos;

  always_comb begin
    total         = {1'b0, act_high} + {1'b0, act_low};
    stat.idle     = ~run | (total == '0);
    stat.boundary = ~stat.idle & (pos == total - SUM_W'(1));
    pwm_out       = run & (pos < {1'b0, act_high});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             pos <= '0;
    else if (load || stat.idle || stat.boundary) pos <= '0;
    else                                    pos <= pos + SUM_W'(1);
  end

  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !stat.idle |-> (pos < total)); // R11
  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pos == '0)); // R4
  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> (pos == '0)); // R5
  AST_ZERO_LOW_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act_high != '0 && act_low == '0) |-> pwm_out); // R7
endmodule

// File: rtl/dcp_pwm_top.sv
module dcp_pwm_top
  import dcp_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);
  logic [CNT_W-1:0] shd_high, shd_low, act_high, act_low;
  logic run_q, upd_req, upd_run, load;
  gen_stat_t stat;

  dcp_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .rdata(bus_rdata), .shd_high(shd_high), .shd_low(shd_low), .run_q(run_q),
    .upd_req(upd_req), .upd_run(upd_run)
  );

  dcp_commit #(.CNT_W(CNT_W)) u_commit (
    .clk(clk), .rst_n(rst_n), .upd_req(upd_req), .upd_run(upd_run),
    .shd_high(shd_high), .shd_low(shd_low), .stat(stat),
    .act_high(act_high), .act_low(act_low), .load(load)
  );

  dcp_gen #(.CNT_W(CNT_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .run(run_q), .load(load),
    .act_high(act_high), .act_low(act_low), .pwm_out(pwm_out), .stat(stat)
  );

  AST_GATED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !pwm_out); // R4
  AST_ZERO_HIGH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (act_high == '0) |-> !pwm_out); // R6
endmodule

// File: tb/tb_dcp_pwm_top.sv
module tb_dcp_pwm_top;
  localparam time CLK_P = 4ns;
  localparam logic [7:0] A_CTRL = 8'h00, A_LOW = 8'h18, A_HIGH = 8'h1C;
  localparam logic [31:0] C_EN = 32'h1, C_UPD = 32'h20, C_DRV = 32'h4000;
  localparam logic [31:0] C_EXTRA = 32'h0604; // bits 2, 9, 10

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic pwm_out;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  dcp_pwm_top dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
                   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
    bus_addr = a; #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic exp_lvl(int hi, int lo, int j);
    if (hi == 0) return 1'b0;
    return ((j % (hi + lo)) < hi);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {31'b0, pwm_out}, 0);
    rd("R1", A_CTRL, 0); rd("R1", A_LOW, 0); rd("R1", A_HIGH, 0);
    rst_n = 1'b1;
    step();

    // Sweep all small high/low pairs, each started from idle
    for (int hi = 0; hi <= 4; hi++) begin
      for (int lo = 0; lo <= 4; lo++) begin
        logic [31:0] cw;
        cw = C_EN | C_DRV | C_UPD | (((hi + lo) % 2 == 1) ? C_EXTRA : 32'h0);
        wr(A_CTRL, 32'h0);
        chk("R4", {31'b0, pwm_out}, 0);
        wr(A_HIGH, hi); wr(A_LOW, lo);
        wr(A_CTRL, cw);
        for (int j = 0; j < 2 * (hi + lo) + 3; j++) begin
          string tag;
          if (hi == 0)                tag = "R6";
          else if (lo == 0)           tag = "R7";
          else if (j == 0)            tag = "R8";
          else if (cw & C_EXTRA)      tag = "R10";
          else                        tag = "R5";
          chk(tag, {31'b0, pwm_out}, {31'b0, exp_lvl(hi, lo, j)});
          step();
        end
      end
    end
    rd("R10", A_CTRL, C_EN | C_DRV | C_UPD);

    // Gating: one run bit alone keeps output low
    wr(A_CTRL, 32'h0);
    wr(A_HIGH, 2); wr(A_LOW, 1);
    wr(A_CTRL, C_EN | C_UPD);
    for (int j = 0; j < 4; j++) begin chk("R4", {31'b0, pwm_out}, 0); step(); end
    wr(A_CTRL, C_DRV | C_UPD);
    for (int j = 0; j < 4; j++) begin chk("R4", {31'b0, pwm_out}, 0); step(); end

    // Running sequence: shadow writes, plain control write, held-back update
    wr(A_CTRL, 32'h0);
    wr(A_HIGH, 3); wr(A_LOW, 2);
    wr(A_CTRL, C_EN | C_DRV | C_UPD);        // pos 0
    chk("R8", {31'b0, pwm_out}, 1);
    wr(A_HIGH, 1);                            // pos 1
    chk("R3", {31'b0, pwm_out}, 1);
    wr(A_LOW, 1);                             // pos 2
    chk("R3", {31'b0, pwm_out}, 1);
    wr(A_CTRL, C_EN | C_DRV);                 // pos 3, no update
    chk("R3", {31'b0, pwm_out}, 0);
    step(); chk("R3", {31'b0, pwm_out}, 0);   // pos 4
    step(); chk("R3", {31'b0, pwm_out}, 1);   // pos 0, old counts still
    step(); chk("R3", {31'b0, pwm_out}, 1);   // pos 1
    wr(A_CTRL, C_EN | C_DRV | C_UPD);         // pos 2, update held
    chk("R9", {31'b0, pwm_out}, 1);
    step(); chk("R9", {31'b0, pwm_out}, 0);   // pos 3
    step(); chk("R9", {31'b0, pwm_out}, 0);   // pos 4
    step(); chk("R9", {31'b0, pwm_out}, 1);   // new period, high 1
    step(); chk("R9", {31'b0, pwm_out}, 0);   // low 1
    step(); chk("R9", {31'b0, pwm_out}, 1);

    // Address map and unmapped offsets
    rd("R2", A_HIGH, 1); rd("R2", A_LOW, 1);
    rd("R2", A_CTRL, C_EN | C_DRV | C_UPD);
    wr(8'h08, 32'hFFFF_FFFF);
    rd("R2", 8'h08, 0); rd("R2", 8'h04, 0);
    rd("R2", A_HIGH, 1); rd("R2", A_LOW, 1);

    // Full-width counts
    wr(A_CTRL, 32'h0);
    wr(A_HIGH, 32'hFFFF_FFFF); wr(A_LOW, 32'hFFFF_FFFF);
    wr(A_CTRL, C_EN | C_DRV | C_UPD);
    for (int j = 0; j < 6; j++) begin chk("R11", {31'b0, pwm_out}, 1); step(); end
    rd("R11", A_HIGH, 32'hFFFF_FFFF); rd("R11", A_LOW, 32'hFFFF_FFFF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule